// File: doc/BRIEF.md
# Serial Channel Setpoint Register Interface

This block is a three-wire serial slave that holds eight 10-bit channel setpoints and one clock-source control bit. A host lowers an active-low enable. It then clocks 16-bit command words in, most significant bit first. When the enable returns high, the block decodes the last word received. If the word is valid, the block writes the addressed setpoint register and the clock-source bit. It also pulses a one-cycle update strobe for that channel.

A buffered serial output re-times the bit that leaves the top of the shift register on each falling serial clock. This output feeds the serial input of the next device in a chain. All devices share the serial clock and the enable, so a stream of 16·m bits loads m devices. The first word sent ends up in the last device, and every device commits together when the shared enable rises.

The serial pins are sampled by the system clock through synchronizers. All state lives in that one domain, so the setpoints and strobes can be used directly.

Top module: `refset_serial_if`

## Requirements
- R1: After reset, every channel code is 0, no update strobe is high, the clock-source bit is 0 (internal), the oscillator driver enable is 0 and the serial output is 0.
- R2: While enable is low, each rising serial clock shifts the data input into a 16-bit register, first bit received ending at bit 15. On the enable's rising edge, a word with bit 15 = 0 writes data bits 9..0 into the channel given by bits 12..10 (binary, channel 0 = 0b000, channel 7 = 0b111).
- R3: Bit 13 of the word has no effect on which channel is written.
- R4: A word whose bit 15 is 1 changes no channel code, no clock-source state and raises no strobe.
- R5: If the enable rises after fewer or more than 16 serial clocks, the commit uses the last 16 bits shifted in, including bits left over from earlier transfers.
- R6: Serial clock edges while enable is high shift nothing: the serial output stays constant, and a later commit with no clocks reuses the unchanged register.
- R7: On each falling serial clock while enable is low, the serial output takes the current bit 15 of the shift register. A bit therefore appears on the output at the 16th falling edge after it was shifted in.
- R8: Each committed valid word raises exactly one update strobe, that of the addressed channel, for exactly one system clock cycle, in the cycle its code takes the new value.
- R9: Bit 14 of a valid word sets the clock-source bit (0 internal, 1 external). The oscillator driver enable stays 0 until the first valid word, then equals the inverse of the clock-source bit.
- R10: Channels not addressed by a commit keep their codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial clock from the host or chain |
| ser_din_i | input | 1 | Serial data input |
| ser_en_n_i | input | 1 | Active-low transfer enable; rising edge commits |
| ser_dout_o | output | 1 | Re-timed serial output for the next device |
| chan_codes_o | output | 80 | Channel codes, channel i in bits i*10+9..i*10 |
| chan_upd_o | output | 8 | One-cycle update strobe per channel |
| osc_ext_o | output | 1 | Clock-source select, 1 = external |
| osc_drive_o | output | 1 | Oscillator pin driver enable (0 = high impedance) |

## Verification
The embedded assertions take for granted that each level of the serial clock and of the enable lasts longer than the synchronizer depth plus one system clock. This way every serial edge becomes exactly one event. They also assume the serial clock is low when enable falls, and that enable never moves in the same sampled cycle as a serial clock edge. The stimulus holds every serial level for eight system clocks and changes data and enable only while the serial clock is low. This keeps the serial edges and the enable release well separated, so each one is seen as a single event.

// File: rtl/refset_pkg.sv
package refset_pkg;

    localparam int WORD_W   = 16;
    localparam int CODE_W   = 10;
    localparam int CH_N     = 8;
    localparam int ADDR_W   = 4;
    localparam int CH_IDX_W = $clog2(CH_N);

    // command word layout, most significant field first
    typedef struct packed {
        logic              test_bit;
        logic              osc_sel;
        logic [ADDR_W-1:0] addr;
        logic [CODE_W-1:0] code;
    } cmd_t;

    // decoded write request
    typedef struct packed {
        logic                vld;
        logic                osc_sel;
        logic [CH_IDX_W-1:0] ch;
        logic [CODE_W-1:0]   code;
    } wr_t;

    // serial event seen in the system clock domain
    typedef enum logic [1:0] {
        EV_IDLE,
        EV_SHIFT,
        EV_LAUNCH,
        EV_COMMIT
    } ser_ev_e;

    function automatic wr_t decode_cmd(input logic [WORD_W-1:0] word);
        cmd_t c;
        wr_t  w;
        c         = cmd_t'(word);
        w.vld     = ~c.test_bit;
        w.osc_sel = c.osc_sel;
        w.ch      = c.addr[CH_IDX_W-1:0];
        w.code    = c.code;
        return w;
    endfunction

endpackage

// File: rtl/refset_sync.sv
module refset_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/refset_shifter.sv
module refset_shifter
    import refset_pkg::*;
#(
    parameter int SH_W = WORD_W
) (
    input  logic            clk,
    input  logic            rst,
    input  ser_ev_e         ev,
    input  logic            din,
    output logic [SH_W-1:0] word_o,
    output logic            dout_o
);

    logic [SH_W-1:0] sh_q;
    logic            dout_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            dout_q <= 1'b0;
        end else begin
            case (ev)
                EV_SHIFT:  sh_q   <= {sh_q[SH_W-2:0], din};
                EV_LAUNCH: dout_q <= sh_q[SH_W-1];
                default: ;
            endcase
        end
    end

    assign word_o = sh_q;
    assign dout_o = dout_q;

    AST_DOUT_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (ev != EV_LAUNCH) |=> $stable(dout_o)); // R7
    AST_WORD_HOLDS_OFF_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (ev != EV_SHIFT) |=> $stable(word_o)); // R6

endmodule

// File: rtl/refset_regfile.sv
module refset_regfile
    import refset_pkg::*;
#(
    parameter int NCH = CH_N,
    parameter int CW  = CODE_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            commit,
    input  wr_t             wr,
    output logic [NCH*CW-1:0] codes_o,
    output logic [NCH-1:0]  upd_o,
    output logic            osc_ext_o,
    output logic            osc_drive_o
);

    logic [CW-1:0]  code_q [NCH];
    logic [NCH-1:0] upd_q;
    logic           osc_q;
    logic           prog_q;
    logic           do_wr;

    assign do_wr = commit & wr.vld;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                code_q[i] <= '0;
                upd_q[i]  <= 1'b0;
            end else begin
                upd_q[i] <= do_wr && (int'(wr.ch) == i);
                if (do_wr && (int'(wr.ch) == i)) code_q[i] <= wr.code;
            end
        end
        assign codes_o[i*CW +: CW] = code_q[i];

        AST_UPD_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
            upd_o[i] |=> !upd_o[i]); // R8
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            osc_q  <= 1'b0;
            prog_q <= 1'b0;
        end else if (do_wr) begin
            osc_q  <= wr.osc_sel;
            prog_q <= 1'b1;
        end
    end

    assign upd_o       = upd_q;
    assign osc_ext_o   = osc_q;
    assign osc_drive_o = prog_q & ~osc_q;

    AST_UPD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(upd_o)); // R8
    AST_TEST_BIT_DROPS: assert property (@(posedge clk) disable iff (rst)
        (commit && !wr.vld) |=> (upd_o == '0) && $stable(codes_o) && $stable(osc_ext_o)); // R4
    AST_CODES_HOLD: assert property (@(posedge clk) disable iff (rst)
        !do_wr |=> $stable(codes_o)); // R10
    AST_DRIVE_AFTER_PROG: assert property (@(posedge clk) disable iff (rst)
        (prog_q && !do_wr) |=> $stable(osc_drive_o)); // R9

endmodule

// File: rtl/refset_serial_if.sv
module refset_serial_if
    import refset_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int NCH         = CH_N,
    parameter int CW          = CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk_i,
    input  logic              ser_din_i,
    input  logic              ser_en_n_i,
    output logic              ser_dout_o,
    output logic [NCH*CW-1:0] chan_codes_o,
    output logic [NCH-1:0]    chan_upd_o,
    output logic              osc_ext_o,
    output logic              osc_drive_o
);

    logic [2:0]        raw_pins;
    logic [2:0]        syn_pins;
    logic              sclk_s, din_s, en_n_s;
    logic              sclk_q, en_n_q;
    ser_ev_e           ev;
    logic [WORD_W-1:0] word;
    wr_t               wr;

    assign raw_pins = {ser_en_n_i, ser_clk_i, ser_din_i};

    refset_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_pins),
        .q   (syn_pins)
    );

    assign {en_n_s, sclk_s, din_s} = syn_pins;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            en_n_q <= 1'b1;
        end else begin
            sclk_q <= sclk_s;
            en_n_q <= en_n_s;
        end
    end

    // enable release takes priority; clock edges only count while enabled
    always_comb begin
        ev = EV_IDLE;
        if (en_n_s && !en_n_q)                 ev = EV_COMMIT;
        else if (!en_n_s && sclk_s && !sclk_q) ev = EV_SHIFT;
        else if (!en_n_s && !sclk_s && sclk_q) ev = EV_LAUNCH;
    end

    refset_shifter #(
        .SH_W (WORD_W)
    ) u_shift (
        .clk    (clk),
        .rst    (rst),
        .ev     (ev),
        .din    (din_s),
        .word_o (word),
        .dout_o (ser_dout_o)
    );

    assign wr = decode_cmd(word);

    refset_regfile #(
        .NCH (NCH),
        .CW  (CW)
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .commit      (ev == EV_COMMIT),
        .wr          (wr),
        .codes_o     (chan_codes_o),
        .upd_o       (chan_upd_o),
        .osc_ext_o   (osc_ext_o),
        .osc_drive_o (osc_drive_o)
    );

    AST_NO_SHIFT_WHILE_HIGH: assert property (@(posedge clk) disable iff (rst)
        en_n_s |-> (ev != EV_SHIFT) && (ev != EV_LAUNCH)); // R6
    AST_UPD_NEEDS_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (chan_upd_o != '0) |-> $past(ev == EV_COMMIT)); // R2

endmodule

// File: tb/refset_serial_if_tb_top.sv
module refset_serial_if_tb_top;

    localparam int HALF = 8;
    localparam int NCH  = 8;
    localparam int CW   = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic              sclk = 1'b0, sdi = 1'b0, en_n = 1'b1;
    logic              sdo;
    logic [NCH*CW-1:0] codes;
    logic [NCH-1:0]    upd;
    logic              osc_ext, osc_drv;

    refset_serial_if dut_i (
        .clk          (clk),
        .rst          (rst),
        .ser_clk_i    (sclk),
        .ser_din_i    (sdi),
        .ser_en_n_i   (en_n),
        .ser_dout_o   (sdo),
        .chan_codes_o (codes),
        .chan_upd_o   (upd),
        .osc_ext_o    (osc_ext),
        .osc_drive_o  (osc_drv)
    );

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct { int ch; int code; } exp_t;
    exp_t exp_q[$];

    logic [15:0] m_sh = '0;
    int          m_code [NCH];
    logic        m_osc = 1'b0, m_prog = 1'b0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // scoreboard monitor: every strobe must match the oldest expected write (R8)
    always @(negedge clk) begin
        if (!rst && upd != '0) begin
            for (int i = 0; i < NCH; i++) begin
                if (upd[i]) begin
                    if (exp_q.size() == 0) begin
                        chk("R8", "unexpected strobe on channel", i, -1);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        chk("R8", "strobe channel", i, e.ch);
                        chk("R2", "code at strobe", int'(codes[i*CW +: CW]), e.code);
                    end
                end
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bit(input logic b);
        logic exp_sdo;
        sdi = b;
        wait_clk(HALF);
        sclk = 1'b1;
        m_sh = {m_sh[14:0], b};
        wait_clk(HALF);
        sclk = 1'b0;
        exp_sdo = m_sh[15];
        wait_clk(HALF);
        chk("R7", "serial out after falling edge", int'(sdo), int'(exp_sdo));
    endtask

    task automatic check_all();
        for (int i = 0; i < NCH; i++)
            chk("R10", $sformatf("channel %0d code", i), int'(codes[i*CW +: CW]), m_code[i]);
        chk("R9", "clock-source bit", int'(osc_ext), int'(m_osc));
        chk("R9", "oscillator driver enable", int'(osc_drv), int'(m_prog & ~m_osc));
    endtask

    task automatic release_en();
        if (m_sh[15] == 1'b0) begin
            exp_t e;
            e.ch   = int'(m_sh[12:10]);
            e.code = int'(m_sh[9:0]);
            exp_q.push_back(e);
            m_code[e.ch] = e.code;
            m_osc  = m_sh[14];
            m_prog = 1'b1;
        end
        en_n = 1'b1;
        wait_clk(12);
        chk("R8", "pending strobes after commit", exp_q.size(), 0);
        check_all();
    endtask

    task automatic send(input logic [31:0] bits, input int n);
        en_n = 1'b0;
        wait_clk(HALF);
        for (int i = n - 1; i >= 0; i--) shift_bit(bits[i]);
        wait_clk(HALF);
        release_en();
    endtask

    function automatic logic [15:0] mk(input logic t, input logic o, input logic [3:0] a,
                                       input logic [9:0] d);
        return {t, o, a, d};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] w;
        logic        held;
        for (int i = 0; i < NCH; i++) m_code[i] = 0;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(3);

        // R1: reset state
        chk("R1", "all codes", int'(codes != '0), 0);
        chk("R1", "strobes", int'(upd), 0);
        chk("R1", "clock-source bit", int'(osc_ext), 0);
        chk("R1", "oscillator driver enable", int'(osc_drv), 0);
        chk("R1", "serial out", int'(sdo), 0);

        // R2 / R9: basic writes, first valid word enables the driver
        send({16'h0, mk(0, 0, 4'd0, 10'd0)}, 16);
        send({16'h0, mk(0, 0, 4'd0, 10'd1023)}, 16);
        send({16'h0, mk(0, 0, 4'd0, 10'd512)}, 16);
        send({16'h0, mk(0, 0, 4'd2, 10'd513)}, 16);
        send({16'h0, mk(0, 0, 4'd7, 10'd31)}, 16);
        for (int c = 0; c < NCH; c++)
            send({16'h0, mk(0, 0, 4'(c), 10'(c * 97 + 5))}, 16);   // R2 R10

        // R3: address bit 13 set still selects channel 5
        send({16'h0, mk(0, 0, 4'b1101, 10'h2A5)}, 16);
        chk("R3", "channel 5 code with bit 13 set", int'(codes[5*CW +: CW]), 'h2A5);

        // R4: test bit set is discarded
        send({16'h0, mk(1, 1, 4'd5, 10'h011)}, 16);
        chk("R4", "channel 5 unchanged", int'(codes[5*CW +: CW]), 'h2A5);
        chk("R4", "clock source unchanged", int'(osc_ext), 0);

        // R9: external clock source turns the driver off
        send({16'h0, mk(0, 1, 4'd7, 10'd31)}, 16);
        chk("R9", "external mode driver", int'(osc_drv), 0);
        send({16'h0, mk(0, 0, 4'd6, 10'd300)}, 16);

        // R5: short and long transfers use the last sixteen bits
        send({24'h0, 8'hC3}, 8);
        send({12'h0, 4'hF, mk(0, 0, 4'd1, 10'd777)}, 20);
        chk("R5", "channel 1 after long word", int'(codes[1*CW +: CW]), 777);

        // R7: two-word daisy chain stream, first word passes on to serial out
        send({mk(0, 1, 4'd3, 10'd100), mk(0, 0, 4'd4, 10'd200)}, 32);
        chk("R7", "channel 4 takes last word", int'(codes[4*CW +: CW]), 200);

        // R6: serial clocks while enable is high are ignored
        held = sdo;
        sdi  = 1'b1;
        for (int k = 0; k < 4; k++) begin
            wait_clk(HALF); sclk = 1'b1;
            wait_clk(HALF); sclk = 1'b0;
        end
        wait_clk(HALF);
        chk("R6", "serial out stable while disabled", int'(sdo), int'(held));
        en_n = 1'b0;
        wait_clk(HALF);
        release_en();
        chk("R6", "channel 4 rewritten unchanged", int'(codes[4*CW +: CW]), 200);

        wait_clk(20);
        chk("R8", "scoreboard drained", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule